// File: doc/BRIEF.md
# Single-Level Address Translation Unit

This block turns 32-bit client virtual addresses into 36-bit bus physical addresses. It looks each 4KB virtual page up in one flat page table held in memory, and it has no intermediate directory level. A client offers a request made of an address and a read/write flag. The block answers with a physical address and a fault code. A small fully associative translation cache holds recent entries. On a miss, the block reads one 32-bit table entry through a dedicated memory read port.

An entry can map a 4KB page, a 64KB big page or a 1MB superpage. A hit on a larger mapping covers every virtual page in its aligned region. Software uses a register write port to set the following:

- the table base
- a table limit
- the per-fault abort and interrupt policy
- an optional scratch page for redirecting faulting accesses
- a cache clear, which reports itself busy until the sweep is done

Top module: `mmu_xlate`

## Requirements
- R1: After reset, rspValid, ptReqValid, faultIrq and clearBusy are low and reqReady is high.
- R2: On a miss, exactly one table read is issued, with ptReqValid high for one cycle, starting the cycle after acceptance. Its address is (base frame << 12) + 4 * vaddr[31:12]. The response appears the cycle after ptRspValid.
- R3: A request that hits the cache, or that hits the limit check, is answered in the cycle after acceptance, and no table read is issued.
- R4: The table entry format is as follows. Bits [23:0] hold the frame, bit 28 means valid and bit 29 means writeable. A 4KB translation gives rspPaddr = {frame, vaddr[11:0]} with rspCode 0.
- R5: Entry bit 31 marks a 1MB mapping and bit 30 marks a 64KB mapping; bit 31 wins if both are set. A cached large entry hits for any page whose vaddr agrees above bit 20 (1MB) or bit 16 (64KB). The low 8 or 4 page-number bits pass into the frame.
- R6: An entry with bit 28 clear gives rspCode 2. It is never cached, so repeating the access reads the table again.
- R7: A write through an entry with bit 29 clear gives rspCode 3. A read through the same entry succeeds.
- R8: If vaddr[31:12] is greater than or equal to the limit register (select 3, bits [20:0], reset value 0x100000), the result is rspCode 1 and the table is not read, even when the page is cached.
- R9: The policy register is select 1. Bits 0/1 are the abort/irq enables for code 1, bits 2/3 for code 2 and bits 4/5 for code 3. For a faulting response, rspAbort and faultIrq equal the enables for that code. faultIrq is a one-cycle pulse that comes together with rspValid.
- R10: The scratch register is select 2, with the frame in bits [23:0] and the enable in bit 31. A faulting response carries {scratch frame, vaddr[11:0]} when the enable is set, and 0 otherwise.
- R11: Writing select 1 with bit 8 set starts a clear. clearBusy is high for TLB_N cycles, starting the cycle after the write. reqReady is low during that time. Afterwards every page misses.
- R12: A clear written at any point from a miss's acceptance through the cycle of its table response still lets that response be delivered, but the entry is not cached.
- R13: Fills replace cache entries in round-robin order, so TLB_N+1 distinct fills evict the first one.
- R14: The base register is select 0, holding the table base frame in bits [23:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regSel | input | 2 | Register select (0 base, 1 policy/clear, 2 scratch, 3 limit) |
| regWdata | input | 32 | Register write data |
| clearBusy | output | 1 | Cache clear in progress |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqVaddr | input | 32 | Virtual address |
| reqWrite | input | 1 | Request is a write |
| rspValid | output | 1 | Response valid, one cycle |
| rspPaddr | output | 36 | Physical address |
| rspCode | output | 2 | 0 ok, 1 beyond limit, 2 invalid entry, 3 write to read-only |
| rspAbort | output | 1 | Faulting access aborted |
| faultIrq | output | 1 | Fault interrupt pulse |
| ptReqValid | output | 1 | Table read request, one cycle |
| ptReqAddr | output | 36 | Table entry physical address |
| ptRspValid | input | 1 | Table read data valid |
| ptRspData | input | 32 | Table entry |

## Verification
Two events can land in the same cycle: a cache clear and the fill of an in-flight walk. The bench writes the clear in the exact cycle the table response arrives, and in a separate run it writes the clear in the middle of the wait. In both runs the response must still carry the translated address. Once clearBusy drops, the same page must miss and produce a fresh table read. The bench's reference model tracks cache contents and round-robin order, so each expected hit or miss is a timing prediction. That prediction is compared on every clock.

// File: rtl/mmu_xlate_pkg.sv
package mmu_xlate_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int VPN_W      = 20;
  localparam int LIMIT_W    = VPN_W + 1;

  localparam int BIT_SUPER  = 31;
  localparam int BIT_BIG    = 30;
  localparam int BIT_WRITE  = 29;
  localparam int BIT_VALID  = 28;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_LIMIT   = 2'd1,
    FLT_INVALID = 2'd2,
    FLT_WRPROT  = 2'd3
  } fault_e;

  typedef struct packed {
    logic accept;
    logic fastRsp;
    logic walkRsp;
    logic fill;
  } strobe_t;

  // page-number bits that must agree for an entry to cover a page
  function automatic logic [VPN_W-1:0] pageMask(input logic [31:0] pte);
    if (pte[BIT_SUPER])    return 20'hFFF00;
    else if (pte[BIT_BIG]) return 20'hFFFF0;
    else                   return 20'hFFFFF;
  endfunction
endpackage

// File: rtl/mmu_xlate_ctrl.sv
module mmu_xlate_ctrl
  import mmu_xlate_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    hit,
  input  logic    limitFlt,
  input  logic    clearReq,
  input  logic    clearBusy,
  input  logic    ptRspValid,
  output logic    reqReady,
  output logic    ptReqValid,
  output strobe_t stb
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} state_e;
  state_e state;
  logic   dropFill;

  always_comb begin
    reqReady    = (state == ST_IDLE) && !clearBusy;
    ptReqValid  = (state == ST_ISSUE);
    stb.accept  = reqValid && reqReady;
    stb.fastRsp = stb.accept && (hit || limitFlt);
    stb.walkRsp = (state == ST_WAIT) && ptRspValid;
    stb.fill    = stb.walkRsp && !dropFill && !clearReq && !clearBusy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      dropFill <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE:  if (stb.accept && !stb.fastRsp) state <= ST_ISSUE;
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT:  if (ptRspValid) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
      if (state == ST_IDLE) dropFill <= clearReq;
      else if (clearReq)    dropFill <= 1'b1;
    end
  end

  a_r2_single_read: assert property (@(posedge clk) disable iff (!rstN)
    ptReqValid |=> !ptReqValid);
  a_r11_hold_off: assert property (@(posedge clk) disable iff (!rstN)
    clearBusy |-> !reqReady);
  a_r3_no_fetch_fast: assert property (@(posedge clk) disable iff (!rstN)
    stb.fastRsp |=> !ptReqValid);
  a_r12_no_fill_clear: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && clearReq) |=> !stb.fill);
endmodule

// File: rtl/mmu_xlate_dp.sv
module mmu_xlate_dp
  import mmu_xlate_pkg::*;
#(
  parameter int TLB_N   = 4,
  parameter int FRAME_W = 24
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWr,
  input  logic [1:0]                  regSel,
  input  logic [31:0]                 regWdata,
  input  logic [31:0]                 reqVaddr,
  input  logic                        reqWrite,
  input  logic [31:0]                 ptRspData,
  input  strobe_t                     stb,
  output logic                        hit,
  output logic                        limitFlt,
  output logic                        clearReq,
  output logic                        clearBusy,
  output logic [FRAME_W+PAGE_SHIFT-1:0] ptReqAddr,
  output logic                        rspValid,
  output logic [FRAME_W+PAGE_SHIFT-1:0] rspPaddr,
  output logic [1:0]                  rspCode,
  output logic                        rspAbort,
  output logic                        faultIrq
);
  localparam int PA_W  = FRAME_W + PAGE_SHIFT;
  localparam int PTR_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;
  localparam int CNT_W = $clog2(TLB_N + 1);

  logic [FRAME_W-1:0] baseFrame, scratchFrame;
  logic               scratchEn;
  logic [5:0]         policy;
  logic [LIMIT_W-1:0] limitReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseFrame    <= '0;
      scratchFrame <= '0;
      scratchEn    <= 1'b0;
      policy       <= '0;
      limitReg     <= LIMIT_W'(1) << VPN_W;
    end else if (regWr) begin
      unique case (regSel)
        2'd0: baseFrame <= regWdata[FRAME_W-1:0];
        2'd1: policy    <= regWdata[5:0];
        2'd2: begin
          scratchFrame <= regWdata[FRAME_W-1:0];
          scratchEn    <= regWdata[31];
        end
        default: limitReg <= regWdata[LIMIT_W-1:0];
      endcase
    end
  end

  assign clearReq = regWr && (regSel == 2'd1) && regWdata[8];

  // translation cache
  logic [TLB_N-1:0] tVal;
  logic [VPN_W-1:0] tVpn [TLB_N];
  logic [31:0]      tPte [TLB_N];
  logic [PTR_W-1:0] fillPtr;
  logic [CNT_W-1:0] clrCnt;
  logic [31:0]      hitPte;
  logic [VPN_W-1:0] vpnIn;

  assign vpnIn     = reqVaddr[31:PAGE_SHIFT];
  assign limitFlt  = {1'b0, vpnIn} >= limitReg;
  assign clearBusy = (clrCnt != '0);

  always_comb begin
    hit    = 1'b0;
    hitPte = '0;
    for (int i = TLB_N - 1; i >= 0; i--) begin
      if (tVal[i] && (((tVpn[i] ^ vpnIn) & pageMask(tPte[i])) == '0)) begin
        hit    = 1'b1;
        hitPte = tPte[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tVal    <= '0;
      fillPtr <= '0;
      clrCnt  <= '0;
    end else begin
      if (clrCnt != '0) begin
        tVal[PTR_W'(clrCnt - 1'b1)] <= 1'b0;
        clrCnt <= clrCnt - 1'b1;
      end
      if (clearReq) clrCnt <= CNT_W'(TLB_N);
      if (stb.fill && ptRspData[BIT_VALID]) begin
        tVal[fillPtr] <= 1'b1;
        fillPtr <= (fillPtr == PTR_W'(TLB_N - 1)) ? '0 : fillPtr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.fill && ptRspData[BIT_VALID]) begin
      tVpn[fillPtr] <= curVaddr[31:PAGE_SHIFT];
      tPte[fillPtr] <= ptRspData;
    end
  end

  // request under walk
  logic [31:0] curVaddr;
  logic        curWrite;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curVaddr <= '0;
      curWrite <= 1'b0;
    end else if (stb.accept) begin
      curVaddr <= reqVaddr;
      curWrite <= reqWrite;
    end
  end

  assign ptReqAddr = {baseFrame, {PAGE_SHIFT{1'b0}}}
                   + PA_W'({curVaddr[31:PAGE_SHIFT], 2'b00});

  // response evaluation
  logic [31:0]        selVaddr, selPte;
  logic               selWrite, selLimit;
  fault_e             code;
  logic [FRAME_W-1:0] keepMask, frame;
  logic [PA_W-1:0]    paddr;
  logic               abortBit, irqBit;

  always_comb begin
    if (stb.fastRsp) begin
      selVaddr = reqVaddr;  selWrite = reqWrite;
      selPte   = hitPte;    selLimit = limitFlt;
    end else begin
      selVaddr = curVaddr;  selWrite = curWrite;
      selPte   = ptRspData; selLimit = 1'b0;
    end
    if (selLimit)                                  code = FLT_LIMIT;
    else if (!selPte[BIT_VALID])                   code = FLT_INVALID;
    else if (selWrite && !selPte[BIT_WRITE])       code = FLT_WRPROT;
    else                                           code = FLT_NONE;
    keepMask = {{(FRAME_W - VPN_W){1'b1}}, pageMask(selPte)};
    frame    = (selPte[FRAME_W-1:0] & keepMask)
             | ({{(FRAME_W - VPN_W){1'b0}}, selVaddr[31:PAGE_SHIFT]} & ~keepMask);
    if (code == FLT_NONE) paddr = {frame, selVaddr[PAGE_SHIFT-1:0]};
    else if (scratchEn)   paddr = {scratchFrame, selVaddr[PAGE_SHIFT-1:0]};
    else                  paddr = '0;
    unique case (code)
      FLT_LIMIT:   begin abortBit = policy[0]; irqBit = policy[1]; end
      FLT_INVALID: begin abortBit = policy[2]; irqBit = policy[3]; end
      FLT_WRPROT:  begin abortBit = policy[4]; irqBit = policy[5]; end
      default:     begin abortBit = 1'b0;      irqBit = 1'b0;      end
    endcase
  end

  logic unusedBits;
  assign unusedBits = ^{regWdata, selPte};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspPaddr <= '0;
      rspCode  <= '0;
      rspAbort <= 1'b0;
      faultIrq <= 1'b0;
    end else begin
      rspValid <= stb.fastRsp || stb.walkRsp;
      faultIrq <= (stb.fastRsp || stb.walkRsp) && irqBit;
      if (stb.fastRsp || stb.walkRsp) begin
        rspPaddr <= paddr;
        rspCode  <= code;
        rspAbort <= abortBit;
      end
    end
  end

  a_r11_swept_empty: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clearBusy) |-> (tVal == '0));
  a_r9_irq_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    faultIrq |-> (rspValid && rspCode != 2'd0));
  a_r6_only_valid_cached: assert property (@(posedge clk) disable iff (!rstN)
    $changed(fillPtr) && !$past(clearReq) |-> $past(ptRspData[BIT_VALID]));
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_xlate_pkg::*;
#(
  parameter int TLB_N   = 4,
  parameter int FRAME_W = 24
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWr,
  input  logic [1:0]                    regSel,
  input  logic [31:0]                   regWdata,
  output logic                          clearBusy,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [31:0]                   reqVaddr,
  input  logic                          reqWrite,
  output logic                          rspValid,
  output logic [FRAME_W+PAGE_SHIFT-1:0] rspPaddr,
  output logic [1:0]                    rspCode,
  output logic                          rspAbort,
  output logic                          faultIrq,
  output logic                          ptReqValid,
  output logic [FRAME_W+PAGE_SHIFT-1:0] ptReqAddr,
  input  logic                          ptRspValid,
  input  logic [31:0]                   ptRspData
);
  strobe_t stb;
  logic    hit, limitFlt, clearReq;

  mmu_xlate_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .hit        (hit),
    .limitFlt   (limitFlt),
    .clearReq   (clearReq),
    .clearBusy  (clearBusy),
    .ptRspValid (ptRspValid),
    .reqReady   (reqReady),
    .ptReqValid (ptReqValid),
    .stb        (stb)
  );

  mmu_xlate_dp #(.TLB_N(TLB_N), .FRAME_W(FRAME_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regSel    (regSel),
    .regWdata  (regWdata),
    .reqVaddr  (reqVaddr),
    .reqWrite  (reqWrite),
    .ptRspData (ptRspData),
    .stb       (stb),
    .hit       (hit),
    .limitFlt  (limitFlt),
    .clearReq  (clearReq),
    .clearBusy (clearBusy),
    .ptReqAddr (ptReqAddr),
    .rspValid  (rspValid),
    .rspPaddr  (rspPaddr),
    .rspCode   (rspCode),
    .rspAbort  (rspAbort),
    .faultIrq  (faultIrq)
  );
endmodule

// File: tb/mmu_xlate_test.sv
module mmu_xlate_test;
  localparam int N   = 4;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regSel = '0;
  logic [31:0] regWdata = '0;
  logic        clearBusy;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        rspValid;
  logic [35:0] rspPaddr;
  logic [1:0]  rspCode;
  logic        rspAbort;
  logic        faultIrq;
  logic        ptReqValid;
  logic [35:0] ptReqAddr;
  logic        ptRspValid = 1'b0;
  logic [31:0] ptRspData = '0;

  always #5 clk = ~clk;

  mmu_xlate #(.TLB_N(N), .FRAME_W(24)) uut (.*);

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // reference model state
  logic [31:0] ptMem [int];
  int          mVpn [N];
  logic [31:0] mPte [N];
  bit          mVal [N];
  int          mPtr = 0;
  longint      mBase = 0;
  int          mPolicy = 0;
  longint      mScr = 0;
  bit          mScrEn = 0;
  int          mLimit = 32'h100000;

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic int sizeShift(input logic [31:0] pte);
    if (pte[31]) return 8;
    if (pte[30]) return 4;
    return 0;
  endfunction

  task automatic modelClear();
    for (int i = 0; i < N; i++) mVal[i] = 0;
  endtask

  task automatic regWrite(input int sel, input logic [31:0] d, input string rq);
    @(negedge clk);
    regWr = 1'b1; regSel = sel[1:0]; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
    case (sel)
      0: mBase = d[23:0];
      1: mPolicy = d[5:0];
      2: begin mScr = d[23:0]; mScrEn = d[31]; end
      default: mLimit = d[20:0];
    endcase
    if (sel == 1 && d[8]) begin
      modelClear();
      for (int k = 1; k <= N; k++) begin
        if (k > 1) @(negedge clk);
        chk(rq, "clearBusy during sweep", clearBusy, 1);
        chk(rq, "reqReady during sweep", reqReady, 0);
      end
      @(negedge clk);
      chk(rq, "clearBusy after sweep", clearBusy, 0);
      chk(rq, "reqReady after sweep", reqReady, 1);
    end
  endtask

  task automatic xact(input logic [31:0] va, input bit wr, input int clrAt, input string rq);
    int vpn = int'(va[31:12]);
    int off = int'(va[11:0]);
    bit lim, miss;
    int hi = -1;
    int code, expIdx, k;
    logic [31:0] pte;
    longint epa, frame;
    bit eAb, eIrq;
    lim = vpn >= mLimit;
    for (int i = 0; i < N; i++)
      if (hi < 0 && mVal[i] && (((mVpn[i] ^ vpn) >> sizeShift(mPte[i])) == 0)) hi = i;
    miss = !lim && hi < 0;
    pte = (hi >= 0) ? mPte[hi] : (ptMem.exists(vpn) ? ptMem[vpn] : 32'h0);
    if (lim) code = 1;
    else if (!pte[28]) code = 2;
    else if (wr && !pte[29]) code = 3;
    else code = 0;
    k = sizeShift(pte);
    frame = ((longint'(pte[23:0]) >> k) << k) | (longint'(vpn) & ((64'd1 << k) - 1));
    if (code == 0) epa = (frame << 12) | off;
    else if (mScrEn) epa = (mScr << 12) | off;
    else epa = 0;
    eAb  = (code != 0) && mPolicy[2*(code-1)];
    eIrq = (code != 0) && mPolicy[2*(code-1)+1];
    expIdx = miss ? LAT + 2 : 1;

    @(negedge clk);
    chk(rq, "reqReady before request", reqReady, 1);
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr;
    for (int idx = 1; idx <= expIdx; idx++) begin
      @(negedge clk);
      chk(rq, "rspValid", rspValid, idx == expIdx);
      chk(rq, "ptReqValid", ptReqValid, miss && idx == 1);
      if (miss && idx == 1)
        chk(rq, "ptReqAddr", ptReqAddr, (mBase << 12) + longint'(vpn) * 4);
      if (idx == expIdx) begin
        chk(rq, "rspPaddr", rspPaddr, epa);
        chk(rq, "rspCode", rspCode, code);
        chk(rq, "rspAbort", rspAbort, eAb);
        chk(rq, "faultIrq", faultIrq, eIrq);
      end
      if (idx == 1) reqValid = 1'b0;
      ptRspValid = miss && (idx == 1 + LAT);
      ptRspData  = pte;
      if (clrAt > 0 && idx == clrAt) begin
        regWr = 1'b1; regSel = 2'd1; regWdata = 32'h100 | mPolicy;
      end else regWr = 1'b0;
    end
    @(negedge clk);
    chk(rq, "rspValid drops", rspValid, 0);
    chk(rq, "faultIrq drops", faultIrq, 0);
    if (miss && pte[28] && clrAt == 0) begin
      mVpn[mPtr] = vpn; mPte[mPtr] = pte; mVal[mPtr] = 1;
      mPtr = (mPtr + 1) % N;
    end
    if (clrAt > 0) begin
      modelClear();
      repeat (N + 1) @(negedge clk);
      chk(rq, "clearBusy after mid-walk clear", clearBusy, 0);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) mVal[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "rspValid", rspValid, 0);
    chk("R1", "reqReady", reqReady, 1);
    chk("R1", "clearBusy", clearBusy, 0);
    chk("R1", "ptReqValid", ptReqValid, 0);
    chk("R1", "faultIrq", faultIrq, 0);

    // R14 base register, R2 miss walk, R4 4KB translation
    regWrite(0, 32'h0012345, "R14");
    ptMem[32'h10]  = 32'h3000_0000 | 32'hABCDE;
    xact(32'h0001_0123, 0, 0, "R2");
    xact(32'h0001_0FFC, 1, 0, "R3");     // hit
    // R5 big page then super page
    ptMem[32'h20]  = 32'h7000_0000 | 32'h00550;
    xact(32'h0002_0004, 0, 0, "R5");
    xact(32'h0002_FABC, 0, 0, "R5");
    ptMem[32'h300] = 32'h9000_0000 | 32'h01200;  // read-only superpage
    xact(32'h0030_0000, 0, 0, "R5");
    xact(32'h003A_7010, 0, 0, "R5");
    xact(32'h003A_7010, 1, 0, "R7");
    // R6 invalid entry, not cached
    xact(32'h0040_0010, 0, 0, "R6");
    xact(32'h0040_0010, 0, 0, "R6");
    // R9 policy, R10 scratch redirect
    regWrite(1, 32'h0000_000C, "R9");
    regWrite(2, 32'h8000_0777, "R10");
    xact(32'h0040_00F0, 0, 0, "R9");
    regWrite(1, 32'h0000_0020, "R9");
    xact(32'h0030_0008, 1, 0, "R10");
    regWrite(2, 32'h0000_0777, "R10");
    xact(32'h0030_0008, 1, 0, "R10");
    // R8 limit beyond cached page
    regWrite(3, 32'h0000_0100, "R8");
    regWrite(1, 32'h0000_0003, "R8");
    xact(32'h0030_0000, 0, 0, "R8");
    xact(32'h0000_F004, 0, 0, "R8");
    regWrite(3, 32'h0010_0000, "R8");
    // R13 round-robin eviction
    ptMem[32'h50] = 32'h3000_0000 | 32'h00A50;
    ptMem[32'h60] = 32'h3000_0000 | 32'h00A60;
    xact(32'h0005_0000, 0, 0, "R13");
    xact(32'h0006_0000, 0, 0, "R13");
    xact(32'h0001_0000, 0, 0, "R13");
    xact(32'h0005_0040, 0, 0, "R13");
    // R11 clear sweep
    regWrite(1, 32'h0000_0103, "R11");
    xact(32'h0005_0040, 0, 0, "R11");
    // R12 clear mid-walk and in the response cycle
    ptMem[32'h70] = 32'h3000_0000 | 32'h00B70;
    xact(32'h0007_0008, 0, 2, "R12");
    xact(32'h0007_0008, 0, 0, "R12");
    xact(32'h0006_0008, 0, LAT + 1, "R12");
    xact(32'h0006_0008, 0, 0, "R12");
    xact(32'h0006_0008, 0, 0, "R3");
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule